// File: doc/BRIEF.md
# Network Controller Bring-Up Sequencer

This block takes an attached network controller from power-up to a usable state without software help. It talks to the controller through a simple register access port: one request at a time, with a write or read select, an address and 16 bits of write data. The controller answers each request with a done pulse, and read data is valid in that same cycle. The serial or parallel link that carries these accesses lies outside the block.

The sequence has four parts. First the block proves the link works: it writes 0x1234 into a scratch register and reads it back, and it repeats this pair until the readback matches. Next it polls a status register until the clock-ready flag is set. Then it writes the reset bit of a control register. After a timed pause it reads the scratch register again. A zero shows that the reset took effect. A non-zero value restarts the whole procedure. A second, longer timed pause follows, and then the block raises `ready`. The two pauses are set in microseconds and converted to clock cycles from a clock-frequency parameter, rounding up.

`busy` stays high from reset until `ready` rises. `ready` then stays high until the next synchronous reset.

Top module: `brup_seq`

## Requirements
- R1: While `rst` is high and after it falls, `ready` is 0 and `busy` is 1. The first request after release is a write (`reg_wr`=1) of 0x1234 to SCRATCH_ADDR (default 0x16).
- R2: Each completed scratch write is followed by a read of SCRATCH_ADDR. If that readback is not 0x1234, the next request is the scratch write again.
- R3: After a 0x1234 readback, the block reads STATUS_ADDR (default 0x1A). It repeats that read until bit 12 of the returned data is 1.
- R4: Once bit 12 is seen set, the next request writes 0x0010 (bit 4 set, all other bits 0) to CTRL_ADDR (default 0x6E).
- R5: After the cycle in which the control write completes, no request is raised for at least ceil(CLK_HZ × RST_WAIT_US / 10^6) cycles (83 cycles at 3.3 MHz with 25 µs).
- R6: After that pause the block reads SCRATCH_ADDR. If the readback is 0x0000 it proceeds. Any other value restarts the procedure at the R1 write.
- R7: After the confirming zero readback completes, `ready` stays 0 and no request is raised for at least ceil(CLK_HZ × PHY_WAIT_US / 10^6) cycles (845 cycles at 3.3 MHz with 256 µs). Then `ready` rises.
- R8: `busy` is always the complement of `ready`. Once `ready` is 1 it stays 1 with no further requests until `rst` is asserted.
- R9: A request keeps `reg_req` high, with `reg_wr`, `reg_addr` and `reg_wdata` stable, until the cycle in which `reg_done` is 1. `reg_req` is 0 in the following cycle.
- R10: A `reg_done` pulse while `reg_req` is 0 has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | output | 1 | Register access request, held until done |
| reg_wr | output | 1 | 1 selects a write, 0 a read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid while reg_done is 1 |
| reg_done | input | 1 | Access complete, sampled only while reg_req is 1 |
| ready | output | 1 | Controller brought up; sticky until reset |
| busy | output | 1 | Sequence in progress |

## Verification
The checker counts its two quiet windows from the cycle in which `reg_req` and `reg_done` are both high. It takes any completed write to the control address as the reset write. It takes the first scratch read after that write as the confirming read. Both hold only if the controller answers every request with exactly one done pulse, and read data is meaningful only in that cycle. The bench's responder keeps to this. It raises done only against a request it has seen, after a random latency, and returns data in that cycle. Its stray done pulses fall only in cycles where no request is pending.

// File: rtl/brup_pkg.sv
package brup_pkg;

    parameter int unsigned BRUP_AW = 8;
    parameter int unsigned BRUP_DW = 16;

    localparam logic [BRUP_DW-1:0] BRUP_MAGIC     = 16'h1234;
    localparam int unsigned        BRUP_CLKRDY_BIT = 12;
    localparam int unsigned        BRUP_RST_BIT    = 4;
    localparam logic [BRUP_DW-1:0] BRUP_RST_WORD  = BRUP_DW'(1) << BRUP_RST_BIT;

    typedef enum logic [3:0] {
        ST_SCR_WR,
        ST_SCR_RD,
        ST_CLK_POLL,
        ST_RST_WR,
        ST_RST_WAIT,
        ST_RST_CHK,
        ST_PHY_WAIT,
        ST_READY
    } brup_state_e;

    typedef struct packed {
        logic               wr;
        logic [BRUP_AW-1:0] addr;
        logic [BRUP_DW-1:0] data;
    } brup_op_t;

    // Cycles needed to cover a wait of 'us' microseconds, rounded up.
    function automatic int unsigned brup_us_to_cycles(longint unsigned hz,
                                                      longint unsigned us);
        longint unsigned c;
        c = (hz * us + 64'd999_999) / 64'd1_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic logic brup_is_access(brup_state_e s);
        return (s == ST_SCR_WR) || (s == ST_SCR_RD) || (s == ST_CLK_POLL) ||
               (s == ST_RST_WR) || (s == ST_RST_CHK);
    endfunction

endpackage

// File: rtl/brup_timer.sv
module brup_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          expired
);
    logic          run_q;
    logic [CW-1:0] cnt_q;

    // Loaded with N-1, the timer flags expiry N cycles after the load edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            cnt_q <= val;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/brup_port.sv
module brup_port
    import brup_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  brup_op_t           op,
    input  logic               reg_done,
    input  logic [BRUP_DW-1:0] reg_rdata,
    output logic               reg_req,
    output logic               reg_wr,
    output logic [BRUP_AW-1:0] reg_addr,
    output logic [BRUP_DW-1:0] reg_wdata,
    output logic               idle,
    output logic               ack,
    output logic [BRUP_DW-1:0] rdata
);
    logic     req_q;
    brup_op_t op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            op_q  <= '0;
        end else if (req_q) begin
            if (reg_done) req_q <= 1'b0;
        end else if (go) begin
            req_q <= 1'b1;
            op_q  <= op;
        end
    end

    // Done counts only against an outstanding request.
    assign ack       = req_q && reg_done;
    assign rdata     = reg_rdata;
    assign idle      = !req_q;
    assign reg_req   = req_q;
    assign reg_wr    = op_q.wr;
    assign reg_addr  = op_q.addr;
    assign reg_wdata = op_q.data;
endmodule

// File: rtl/brup_ctrl.sv
module brup_ctrl
    import brup_pkg::*;
#(
    parameter logic [BRUP_AW-1:0] SCR_ADDR  = 8'h16,
    parameter logic [BRUP_AW-1:0] STAT_ADDR = 8'h1A,
    parameter logic [BRUP_AW-1:0] CTL_ADDR  = 8'h6E,
    parameter int unsigned        RST_CYC   = 1,
    parameter int unsigned        PHY_CYC   = 1,
    parameter int unsigned        CW        = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ack,
    input  logic [BRUP_DW-1:0] rdata,
    input  logic               port_idle,
    input  logic               tmr_done,
    output logic               go,
    output brup_op_t           op,
    output logic               tmr_load,
    output logic [CW-1:0]      tmr_val,
    output logic               ready
);
    brup_state_e st_q, st_d;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            ST_SCR_WR:   if (ack) st_d = ST_SCR_RD;
            ST_SCR_RD:   if (ack) st_d = (rdata == BRUP_MAGIC) ? ST_CLK_POLL : ST_SCR_WR;
            ST_CLK_POLL: if (ack && rdata[BRUP_CLKRDY_BIT]) st_d = ST_RST_WR;
            ST_RST_WR: begin
                if (ack) begin
                    st_d     = ST_RST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(RST_CYC - 1);
                end
            end
            ST_RST_WAIT: if (tmr_done) st_d = ST_RST_CHK;
            ST_RST_CHK: begin
                if (ack) begin
                    if (rdata == '0) begin
                        st_d     = ST_PHY_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(PHY_CYC - 1);
                    end else begin
                        st_d = ST_SCR_WR;
                    end
                end
            end
            ST_PHY_WAIT: if (tmr_done) st_d = ST_READY;
            default:     st_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_SCR_WR;
        else     st_q <= st_d;
    end

    always_comb begin
        op = '{wr: 1'b0, addr: SCR_ADDR, data: '0};
        unique case (st_q)
            ST_SCR_WR:   op = '{wr: 1'b1, addr: SCR_ADDR,  data: BRUP_MAGIC};
            ST_CLK_POLL: op = '{wr: 1'b0, addr: STAT_ADDR, data: '0};
            ST_RST_WR:   op = '{wr: 1'b1, addr: CTL_ADDR,  data: BRUP_RST_WORD};
            default:     op = '{wr: 1'b0, addr: SCR_ADDR,  data: '0};
        endcase
    end

    assign go    = brup_is_access(st_q) && port_idle;
    assign ready = (st_q == ST_READY);
endmodule

// File: rtl/brup_seq.sv
module brup_seq
    import brup_pkg::*;
#(
    parameter longint unsigned    CLK_HZ       = 50_000_000,
    parameter longint unsigned    RST_WAIT_US  = 25,
    parameter longint unsigned    PHY_WAIT_US  = 256,
    parameter logic [BRUP_AW-1:0] SCRATCH_ADDR = 8'h16,
    parameter logic [BRUP_AW-1:0] STATUS_ADDR  = 8'h1A,
    parameter logic [BRUP_AW-1:0] CTRL_ADDR    = 8'h6E
) (
    input  logic               clk,
    input  logic               rst,
    output logic               reg_req,
    output logic               reg_wr,
    output logic [BRUP_AW-1:0] reg_addr,
    output logic [BRUP_DW-1:0] reg_wdata,
    input  logic [BRUP_DW-1:0] reg_rdata,
    input  logic               reg_done,
    output logic               ready,
    output logic               busy
);
    localparam int unsigned RST_CYC = brup_us_to_cycles(CLK_HZ, RST_WAIT_US);
    localparam int unsigned PHY_CYC = brup_us_to_cycles(CLK_HZ, PHY_WAIT_US);
    localparam int unsigned MAX_CYC = (RST_CYC > PHY_CYC) ? RST_CYC : PHY_CYC;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic               go, idle, ack, tmr_load, tmr_done, rdy;
    logic [CW-1:0]      tmr_val;
    logic [BRUP_DW-1:0] rdata;
    brup_op_t           op;

    brup_ctrl #(
        .SCR_ADDR (SCRATCH_ADDR),
        .STAT_ADDR(STATUS_ADDR),
        .CTL_ADDR (CTRL_ADDR),
        .RST_CYC  (RST_CYC),
        .PHY_CYC  (PHY_CYC),
        .CW       (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ack      (ack),
        .rdata    (rdata),
        .port_idle(idle),
        .tmr_done (tmr_done),
        .go       (go),
        .op       (op),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .ready    (rdy)
    );

    brup_port u_port (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .op       (op),
        .reg_done (reg_done),
        .reg_rdata(reg_rdata),
        .reg_req  (reg_req),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .idle     (idle),
        .ack      (ack),
        .rdata    (rdata)
    );

    brup_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .val    (tmr_val),
        .expired(tmr_done)
    );

    assign ready = rdy;
    assign busy  = !rdy;
endmodule

// File: rtl/brup_seq_chk.sv
module brup_seq_chk
    import brup_pkg::*;
#(
    parameter logic [BRUP_AW-1:0] SCR_ADDR = 8'h16,
    parameter logic [BRUP_AW-1:0] CTL_ADDR = 8'h6E,
    parameter int unsigned        RST_CYC  = 1,
    parameter int unsigned        PHY_CYC  = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_req,
    input logic               reg_wr,
    input logic [BRUP_AW-1:0] reg_addr,
    input logic [BRUP_DW-1:0] reg_wdata,
    input logic [BRUP_DW-1:0] reg_rdata,
    input logic               reg_done,
    input logic               ready,
    input logic               busy
);
    localparam int unsigned CW = $clog2(((RST_CYC > PHY_CYC) ? RST_CYC : PHY_CYC) + 1);

    logic          xfer, rst_wr_done, chk_ok;
    logic [CW-1:0] rst_win, phy_win;
    logic          after_rst;

    assign xfer        = reg_req && reg_done;
    assign rst_wr_done = xfer && reg_wr && (reg_addr == CTL_ADDR);
    assign chk_ok      = xfer && !reg_wr && (reg_addr == SCR_ADDR) && after_rst &&
                         (reg_rdata == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_win   <= '0;
            phy_win   <= '0;
            after_rst <= 1'b0;
        end else begin
            rst_win <= rst_wr_done ? CW'(RST_CYC) : ((rst_win != '0) ? rst_win - 1'b1 : '0);
            phy_win <= chk_ok ? CW'(PHY_CYC) : ((phy_win != '0) ? phy_win - 1'b1 : '0);
            if (rst_wr_done) after_rst <= 1'b1;
            else if (xfer && !reg_wr && (reg_addr == SCR_ADDR)) after_rst <= 1'b0;
        end
    end

    a_r1_magic: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_wr && reg_addr == SCR_ADDR) |-> reg_wdata == BRUP_MAGIC);

    a_r4_rst_word: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_wr && reg_addr == CTL_ADDR) |-> reg_wdata == BRUP_RST_WORD);

    a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
        (rst_win != '0) |-> !reg_req);

    a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        (phy_win != '0) |-> (!reg_req && !ready));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!reg_req && !busy));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_done) |=>
            (reg_req && $stable(reg_wr) && $stable(reg_addr) && $stable(reg_wdata)));

    a_r9_gap: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_done) |=> !reg_req);
endmodule

bind brup_seq brup_seq_chk #(
    .SCR_ADDR(SCRATCH_ADDR),
    .CTL_ADDR(CTRL_ADDR),
    .RST_CYC (RST_CYC),
    .PHY_CYC (PHY_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_req  (reg_req),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .reg_done (reg_done),
    .ready    (ready),
    .busy     (busy)
);

// File: tb/brup_seq_tb.sv
module brup_seq_tb;
    localparam longint unsigned TB_HZ = 3_300_000;
    localparam logic [7:0] A_SCR  = 8'h16;
    localparam logic [7:0] A_STAT = 8'h1A;
    localparam logic [7:0] A_CTL  = 8'h6E;

    function automatic int ceil_cyc(longint unsigned hz, longint unsigned us);
        return int'((hz * us + 64'd999_999) / 64'd1_000_000);
    endfunction

    localparam int RST_EXP = ceil_cyc(TB_HZ, 25);   // 83
    localparam int PHY_EXP = ceil_cyc(TB_HZ, 256);  // 845

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_req, reg_wr, ready, busy;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata = '0;
    logic        reg_done = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    brup_seq #(.CLK_HZ(TB_HZ)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .reg_req  (reg_req),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .reg_done (reg_done),
        .ready    (ready),
        .busy     (busy)
    );

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Expected next access in each phase of the procedure.
    function automatic logic [24:0] exp_op(int ph);
        case (ph)
            0:       return {1'b1, A_SCR,  16'h1234};
            1:       return {1'b0, A_SCR,  16'h0000};
            2:       return {1'b0, A_STAT, 16'h0000};
            3:       return {1'b1, A_CTL,  16'h0010};
            default: return {1'b0, A_SCR,  16'h0000};
        endcase
    endfunction

    function automatic string ph_req(int ph);
        case (ph)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic run_scn(int corrupt, int polls, int rfail, int maxlat, bit spur);
        int          ph = 0, lat = 0, gap = 0, pgap = 0, first = 1;
        bit          hold = 0, just_done = 0, m_rst = 0, m_phy = 0;
        logic [24:0] cap = '0;
        logic [15:0] scr = 16'hBEEF, rd;
        int          start = cyc;

        rst = 1'b1;
        reg_done = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ready && busy && !reg_req, "R1", "state in reset", {ready, busy, reg_req}, 3'b010);
        rst = 1'b0;

        while (!(ph == 5 && ready) && (cyc - start) < 6000) begin
            @(negedge clk);
            reg_done = 1'b0;
            if (busy == ready) chk(0, "R8", "busy not complement of ready", busy, !ready);
            if (just_done) begin
                if (reg_req) chk(0, "R9", "req high after done", 1, 0);
                just_done = 0;
            end
            if (m_rst) begin
                if (!reg_req) gap++;
                else begin
                    chk(gap >= RST_EXP && gap <= RST_EXP + 2, "R5", "quiet cycles after reset write",
                        gap, RST_EXP + 1);
                    m_rst = 0;
                end
            end
            if (m_phy) begin
                if (reg_req) chk(0, "R7", "request during settle wait", 1, 0);
                if (!ready) pgap++;
                else begin
                    chk(pgap >= PHY_EXP && pgap <= PHY_EXP + 1, "R7", "cycles before ready",
                        pgap, PHY_EXP);
                    m_phy = 0;
                end
            end else if (ready && ph != 5) begin
                chk(0, "R7", "ready before sequence end", ph, 5);
            end
            if (reg_req) begin
                if (hold) begin
                    if ({reg_wr, reg_addr, reg_wdata} != cap)
                        chk(0, "R9", "request changed while pending", {reg_wr, reg_addr, reg_wdata}, cap);
                end else begin
                    cap  = {reg_wr, reg_addr, reg_wdata};
                    hold = 1;
                    lat  = $urandom_range(maxlat, 0);
                    chk(cap == exp_op(ph), (first == 1) ? "R1" : ph_req(ph), "access", cap, exp_op(ph));
                    first = 0;
                end
                if (lat == 0) begin
                    // Answer the access and advance the expected procedure.
                    rd = $urandom();
                    if (reg_wr && reg_addr == A_SCR) scr = reg_wdata;
                    else if (!reg_wr && reg_addr == A_SCR) begin
                        rd = scr ^ ((corrupt > 0) ? 16'h0100 : 16'h0000);
                        if (corrupt > 0) corrupt--;
                    end else if (!reg_wr && reg_addr == A_STAT) begin
                        rd[12] = (polls == 0);
                        if (polls > 0) polls--;
                    end else if (reg_wr && reg_addr == A_CTL && reg_wdata[4]) begin
                        if (rfail > 0) rfail--; else scr = 16'h0000;
                    end
                    reg_rdata = rd;
                    reg_done  = 1'b1;
                    hold      = 0;
                    just_done = 1;
                    case (ph)
                        0: ph = 1;
                        1: ph = (rd == 16'h1234) ? 2 : 0;
                        2: ph = rd[12] ? 3 : 2;
                        3: begin ph = 4; m_rst = 1; gap = 0; end
                        4: begin
                            if (rd == 16'h0000) begin ph = 5; m_phy = 1; pgap = 0; end
                            else ph = 0;
                        end
                        default: chk(0, "R8", "access after sequence end", ph, 5);
                    endcase
                end else begin
                    lat--;
                end
            end else if (spur && $urandom_range(3, 0) == 0) begin
                // Stray done with a plausible value: R10 says it must be ignored.
                reg_rdata = 16'h1234;
                reg_done  = 1'b1;
            end
        end
        chk(ready && ph == 5, "R8", "ready reached", {ready, 3'(ph)}, {1'b1, 3'd5});
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            reg_done = 1'b0;
            if (!ready || busy || reg_req)
                chk(0, "R8", "ready not held", {ready, busy, reg_req}, 3'b100);
        end
        chk(ready && !busy, "R8", "ready after hold", {ready, busy}, 2'b10);
    endtask

    initial begin
        void'($urandom(32'd2024));
        run_scn(0, 0, 0, 0, 0);   // straight path, immediate answers
        run_scn(2, 3, 0, 3, 1);   // R2 retries, R3 polling, R10 stray done
        run_scn(0, 1, 1, 2, 1);   // R6 failed reset check, restart
        run_scn(1, 0, 2, 4, 0);   // two failed resets
        for (int s = 0; s < 4; s++)
            run_scn($urandom_range(3, 0), $urandom_range(5, 0), $urandom_range(1, 0),
                    $urandom_range(4, 0), 1'($urandom_range(1, 0)));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 190_000);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule